// File: doc/BRIEF.md
# Triggered Sample Capture Controller

The block records a probe word on design clock edges into an on-chip circular buffer and frames the recording around a trigger event. After an arm pulse it first gathers a programmable number of samples from before the trigger. It then writes circularly while it waits for the trigger, and after the trigger it keeps writing until the buffer is full. It then stops and raises a done flag. The status output reports the current step of this sequence, and the trigger sample's buffer address is latched so that read-out software can align the record.

A mode input chooses between storing every active cycle and storing only the cycles where a qualifying condition input is high. The trigger sample itself is always stored. Once done is set, the record is unloaded through a registered read port.

The buffer depth must be a power of two. The trigger position input is therefore at most DEPTH-1, which always leaves room for the trigger sample.

Top module: `trig_capture`

## Requirements
- R1: After reset, status_o is 0 (idle), done_o is 0, and no sample is written until arm_i is seen.
- R2: An arm pulse latches trig_pos_i and mode_i and restarts the write address and the stored-sample count at 0. In the next cycle status_o is 1 (pre-trigger), or 2 (waiting) when the latched position is 0. Nothing is stored in the arm cycle, and an arm pulse restarts a capture in any state.
- R3: With mode 0 (always), a sample is stored in every cycle while status_o is 1, 2 or 3, whatever cond_i is.
- R4: With mode 1 (qualified), a sample is stored only in cycles where cond_i is 1. The exception is the cycle in which a trigger is accepted while waiting, which is always stored.
- R5: Pre-trigger ends once the number of stored samples equals the latched position, and status_o then becomes 2. A trigger during pre-trigger is ignored.
- R6: A trig_i high while status_o is 2 is accepted. Its sample is written at the current write address, and that address appears on trig_addr_o from the next cycle. It stays there until the next acceptance.
- R7: After the trigger sample, DEPTH-1-P more samples are stored, where P is the latched position, and then status_o becomes 4. At that point buffer address (trig_addr_o - P + k) mod DEPTH holds the k-th sample of the record, for k = 0..DEPTH-1. The trigger sample has k = P.
- R8: While status_o is 4, done_o is 1 and the buffer, trig_addr_o and the status stay unchanged, whatever trig_i, cond_i and data_i do, until the next arm pulse.
- R9: rd_data_o shows the buffer word at rd_addr_i one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Design clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start or restart a capture |
| trig_i | input | 1 | Trigger event |
| cond_i | input | 1 | Capture qualifier used in mode 1 |
| mode_i | input | 1 | 0 stores every cycle, 1 stores qualified cycles |
| trig_pos_i | input | ADDR_W | Number of samples kept before the trigger |
| data_i | input | DATA_W | Probe word |
| rd_addr_i | input | ADDR_W | Read-out address |
| rd_data_o | output | DATA_W | Read-out word, one cycle latency |
| trig_addr_o | output | ADDR_W | Buffer address of the trigger sample |
| status_o | output | 3 | 0 idle, 1 pre-trigger, 2 waiting, 3 post-trigger, 4 done |
| done_o | output | 1 | Capture complete |

## Verification
A wrong pre-trigger count shows on status_o within one cycle of the expected change to waiting. It then shows a second time as a misplaced trig_addr_o and a shifted record at read-out. A store decision that is wrong in either mode leaves the write address off by the number of missed or extra cycles. That in turn shifts when done_o rises and which words sit beside the trigger sample. The bench compares status every cycle and the whole buffer after each capture, so such a fault is reported within the same capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } cap_state_e;

  typedef enum logic {
    MODE_ALWAYS = 1'b0,
    MODE_QUAL   = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/cap_qual.sv
module cap_qual
  import cap_pkg::*;
(
  input  cap_state_e state_i,
  input  cap_mode_e  mode_i,
  input  logic       arm_i,
  input  logic       cond_i,
  input  logic       trig_i,
  output logic       we_o
);
  logic active;
  logic trig_hit;

  assign active   = (state_i == ST_PRE) || (state_i == ST_WAIT) || (state_i == ST_POST);
  assign trig_hit = (state_i == ST_WAIT) && trig_i;

  always_comb begin
    we_o = 1'b0;
    if (active && !arm_i) begin
      unique case (mode_i)
        MODE_ALWAYS: we_o = 1'b1;
        MODE_QUAL:   we_o = cond_i || trig_hit;
        default:     we_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              we_i,
  input  logic              mode_in_i,
  input  logic [ADDR_W-1:0] pos_i,
  output cap_state_e        state_o,
  output cap_mode_e         mode_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [ADDR_W-1:0] trig_addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  cap_state_e        state_q, state_d;
  cap_mode_e         mode_q, mode_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] pos_q, pos_d;
  logic [ADDR_W-1:0] left_q, left_d;
  logic [ADDR_W-1:0] taddr_q, taddr_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    pos_d   = pos_q;
    left_d  = left_q;
    taddr_d = taddr_q;
    if (arm_i) begin
      ptr_d   = '0;
      cnt_d   = '0;
      pos_d   = pos_i;
      mode_d  = cap_mode_e'(mode_in_i);
      state_d = (pos_i == '0) ? ST_WAIT : ST_PRE;
    end else begin
      if (we_i) ptr_d = ptr_q + ADDR_W'(1);
      unique case (state_q)
        ST_PRE: if (we_i) begin
          cnt_d = cnt_q + ADDR_W'(1);
          if (cnt_q + ADDR_W'(1) == pos_q) state_d = ST_WAIT;
        end
        ST_WAIT: if (trig_i) begin
          taddr_d = ptr_q;
          left_d  = LAST - pos_q;
          state_d = (pos_q == LAST) ? ST_DONE : ST_POST;
        end
        ST_POST: if (we_i) begin
          left_d = left_q - ADDR_W'(1);
          if (left_q == ADDR_W'(1)) state_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ALWAYS;
      ptr_q   <= '0;
      cnt_q   <= '0;
      pos_q   <= '0;
      left_q  <= '0;
      taddr_q <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
      pos_q   <= pos_d;
      left_q  <= left_d;
      taddr_q <= taddr_d;
    end
  end

  assign state_o     = state_q;
  assign mode_o      = mode_q;
  assign wr_ptr_o    = ptr_q;
  assign trig_addr_o = taddr_q;

  p_arm_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (state_q == ST_PRE || state_q == ST_WAIT) && ptr_q == '0);
  p_pre_ignores_trig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE && !arm_i) |=> state_q != ST_POST && state_q != ST_DONE);
  p_taddr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && !arm_i) |=> $stable(taddr_q));
  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !arm_i) |=> state_q == ST_DONE && $stable(ptr_q) && $stable(taddr_q));
  p_idle_until_arm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !arm_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/cap_buf.sv
module cap_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              cond_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] trig_pos_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output logic [2:0]        status_o,
  output logic              done_o
);
  cap_state_e        state;
  cap_mode_e         mode_q;
  logic              we;
  logic [ADDR_W-1:0] wr_ptr;

  cap_qual u_qual (
    .state_i (state),
    .mode_i  (mode_q),
    .arm_i   (arm_i),
    .cond_i  (cond_i),
    .trig_i  (trig_i),
    .we_o    (we)
  );

  cap_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .trig_i      (trig_i),
    .we_i        (we),
    .mode_in_i   (mode_i),
    .pos_i       (trig_pos_i),
    .state_o     (state),
    .mode_o      (mode_q),
    .wr_ptr_o    (wr_ptr),
    .trig_addr_o (trig_addr_o)
  );

  cap_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (wr_ptr),
    .wdata_i (data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign status_o = state;
  assign done_o   = (state == ST_DONE);

  p_no_write_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !we);
  p_no_write_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> !we);
  p_always_stores_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ALWAYS && !arm_i && status_o inside {3'd1, 3'd2, 3'd3}) |-> we);
  p_qual_gates_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_QUAL && !cond_i && status_o != 3'd2) |-> !we);
  p_trig_stored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd2 && trig_i && !arm_i) |-> we);
  p_status_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 3'd4);
endmodule

// File: tb/sim_trig_capture.sv
module sim_trig_capture;
  localparam int DW = 8;
  localparam int DP = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, trig = 1'b0, cond = 1'b0, mode = 1'b0;
  logic [AW-1:0] pos = '0, rd_addr = '0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] trig_addr;
  logic [2:0]    status;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  bit finished = 1'b0;

  logic [DW-1:0] hist [0:127];
  int phase, nst, tidx, left, mpos, mmode;

  always #2.5 clk = ~clk;

  trig_capture #(.DATA_W(DW), .DEPTH(DP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_i(trig), .cond_i(cond),
    .mode_i(mode), .trig_pos_i(pos), .data_i(data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .trig_addr_o(trig_addr), .status_o(status), .done_o(done)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0d", req, act, exp, t);
    end
  endtask

  // bench-side reference of the store and phase rules, stepped once per cycle
  task automatic model_step(bit c, bit tr, logic [DW-1:0] d);
    bit st;
    if (phase < 1 || phase > 3) return;
    st = (mmode == 0) || c || (phase == 2 && tr);
    if (st) begin hist[nst] = d; nst++; end
    if (phase == 1) begin
      if (st && nst == mpos) phase = 2;
    end else if (phase == 2) begin
      if (tr) begin
        tidx = nst - 1;
        left = DP - 1 - mpos;
        phase = (left == 0) ? 4 : 3;
      end
    end else if (st) begin
      left--;
      if (left == 0) phase = 4;
    end
  endtask

  task automatic do_arm(int p, int m);
    @(negedge clk); t++;
    arm = 1'b1; pos = AW'(p); mode = m[0];
    data = DW'(t * 37 + 11); cond = 1'b1; trig = 1'b1;
    mpos = p; mmode = m; nst = 0; tidx = -1;
    phase = (p == 0) ? 2 : 1;
    @(posedge clk);
    #1 arm = 1'b0;
  endtask

  task automatic run(int p, int m, int ttrig, int rearm_at);
    int s;
    do_arm(p, m);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); t++;
      chk("R2/R5 status", int'(status), phase);
      chk("R8 done flag", int'(done), int'(phase == 4));
      if (phase == 4) break;
      data = DW'(t * 37 + 11);
      cond = (m == 1) ? ((i % 3) != 1) : ((i % 2) == 0);
      trig = (i == 0) || (i >= ttrig);
      if (i == rearm_at) begin
        arm = 1'b1; pos = AW'(p); mode = m[0];
        nst = 0; tidx = -1; phase = (p == 0) ? 2 : 1;
        @(posedge clk);
        #1 arm = 1'b0;
      end else begin
        model_step(cond, trig, data);
        @(posedge clk);
      end
    end
    // R8: inputs moving while done must not disturb anything
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); t++;
      data = DW'(t * 53 + 7); cond = i[0]; trig = ~i[0];
      @(posedge clk);
      #1 chk("R8 hold status", int'(status), 4);
    end
    chk("R6 trigger address", int'(trig_addr), tidx % DP);
    for (int k = 0; k < DP; k++) begin
      @(negedge clk); t++;
      rd_addr = AW'((tidx - p + k) % DP);
      @(negedge clk); t++;
      s = tidx - p + k;
      chk("R7/R9 record word", int'(rd_data), int'(hist[s]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    // R1: inputs toggling without arm leave it idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); t++;
      trig = i[0]; cond = ~i[0];
      @(negedge clk);
      chk("R1 idle without arm", int'(status), 0);
    end
    // R3 (mode 0), R4 (mode 1), R5 early trigger ignored, all positions
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < DP; p++) begin
        run(p, m, 3, -1);
        run(p, m, 14, -1);
      end
    // R2: arm mid-capture restarts pointer and count
    run(3, 0, 12, 5);
    run(5, 1, 15, 8);
    run(0, 1, 12, 2);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule